// File: doc/BRIEF.md
# Vertical Line Counter with Halt Extension

This block counts the lines of a video frame. It can also make one frame longer than its main counter's range allows. A one-cycle line-advance strobe moves the main count forward. When the count steps onto a programmed stop line, the main count freezes and a secondary counter measures a programmed number of extra lines. After that the main count carries on to the vertical total. The result is a very long frame, as a low refresh rate needs, without widening the main counter.

An external variable-refresh trigger can end a frame early. It is honoured only after the main count has reached the programmed minimum, or while the freeze is running. A small register write port holds shadow copies of the minimum, the total, the stop line, the freeze length and the trigger enable. The shadow copies are moved into the live settings only at a frame boundary.

A combination that would let a trigger during the freeze cut the frame short of its minimum is refused: the freeze is switched off for that frame.

Top module: `vcnt_halt_ext`

## Requirements
- R1: After reset, the main and secondary counts are 0, and frame_start_o, halt_o and vblank_o are all low. The live settings are: minimum, total and stop line all ones, freeze length 0, trigger disabled.
- R2: Each advance strobe that is neither frozen nor wrapping adds one to the main count. An advance at a main count of at least the programmed total (lines minus one) wraps the count to 0.
- R3: A clock with adv_i low changes neither count and raises no frame start.
- R4: When an advance moves the main count onto the stop line and the freeze length T is not zero, halt_o rises. The main count then holds the stop line while the secondary count runs 0 to T-1, one step per advance.
- R5: The advance after the secondary count reaches T-1 drops halt_o and clears the secondary count, and the main count stays at the stop line for that line. A frame therefore lasts total+1+T lines: with total 6, stop 4 and T 5 it lasts 12 lines. The secondary count is 0 whenever halt_o is low.
- R6: With a freeze length of 0, no freeze occurs, and a frame lasts total+1 lines.
- R7: A trigger pulse is accepted only while the trigger is enabled and either the main count is at least the minimum or halt_o is high. An accepted trigger wraps the frame on that same advance, or on the next one if it arrives without an advance. A rejected trigger leaves no trace.
- R8: frame_start_o is high for exactly the one clock after each wrap, whether the wrap comes from the total or from a trigger. In that clock both counts are 0.
- R9: Writes go to shadow settings and reach the live settings at the next wrap. Address map on wr_addr_i: 0 minimum, 1 total, 2 stop line, 3 freeze length, 4 trigger enable (bit 0). Addresses 5 to 7 are ignored. Count values sit in the low bits of wr_data_i.
- R10: If the shadow settings have the trigger enabled, a non-zero freeze length and a minimum above the stop line, the wrap loads a stop line of all ones and a freeze length of 0 instead.
- R11: vblank_o is high exactly when the main count is at least the live stop line.
- R12: If the stop line loaded at a wrap is 0 and its freeze length is not zero, halt_o is already high in the frame-start clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Line-advance strobe, one clock per line |
| trig_i | input | 1 | Variable-refresh trigger pulse |
| wr_en_i | input | 1 | Settings write enable |
| wr_addr_i | input | 3 | Settings address |
| wr_data_i | input | DATA_W | Settings write data |
| main_cnt_o | output | CNT_W | Main line count |
| sec_cnt_o | output | TMR_W | Secondary (freeze) count |
| frame_start_o | output | 1 | One-clock frame-start pulse |
| halt_o | output | 1 | Main count frozen |
| vblank_o | output | 1 | Main count at or past the stop line |

## Verification
The bench builds the block with a 6-bit main counter and a 5-bit freeze counter, so the write bus is 6 bits wide. A full default frame of 64 lines then runs through the all-ones total and stop line within a short test. With these widths the bench can also walk the 12-line frame with total 6, stop 4 and freeze 5 line by line, and end frames by triggers placed before, at and inside the minimum and the freeze window. The fallback case and the case where the stop line is 0 also fall within a few lines.

// File: rtl/vcnt_pkg.sv
package vcnt_pkg;
  localparam int unsigned CFG_AW = 3;

  typedef enum logic [CFG_AW-1:0] {
    CFG_VMIN  = 3'd0,
    CFG_VMAX  = 3'd1,
    CFG_STOP  = 3'd2,
    CFG_TMR   = 3'd3,
    CFG_TRGEN = 3'd4
  } cfg_addr_e;
endpackage

// File: rtl/vcnt_cfg.sv
module vcnt_cfg
  import vcnt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int TMR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CFG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              load_i,
  output logic [CNT_W-1:0]  vmin_o,
  output logic [CNT_W-1:0]  vmax_o,
  output logic [CNT_W-1:0]  stop_o,
  output logic [TMR_W-1:0]  tmr_o,
  output logic              trg_en_o,
  output logic [CNT_W-1:0]  nxt_stop_o,
  output logic [TMR_W-1:0]  nxt_tmr_o
);
  logic [CNT_W-1:0] sh_vmin, sh_vmax, sh_stop;
  logic [TMR_W-1:0] sh_tmr;
  logic             sh_trg;
  logic             unsafe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_vmin <= '1;
      sh_vmax <= '1;
      sh_stop <= '1;
      sh_tmr  <= '0;
      sh_trg  <= 1'b0;
    end else if (wr_en_i) begin
      case (cfg_addr_e'(wr_addr_i))
        CFG_VMIN:  sh_vmin <= wr_data_i[CNT_W-1:0];
        CFG_VMAX:  sh_vmax <= wr_data_i[CNT_W-1:0];
        CFG_STOP:  sh_stop <= wr_data_i[CNT_W-1:0];
        CFG_TMR:   sh_tmr  <= wr_data_i[TMR_W-1:0];
        CFG_TRGEN: sh_trg  <= wr_data_i[0];
        default: ;
      endcase
    end
  end

  // a trigger inside the freeze would cut the frame before its minimum
  assign unsafe     = sh_trg && (sh_tmr != '0) && (sh_vmin > sh_stop);
  assign nxt_stop_o = unsafe ? '1 : sh_stop;
  assign nxt_tmr_o  = unsafe ? '0 : sh_tmr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vmin_o   <= '1;
      vmax_o   <= '1;
      stop_o   <= '1;
      tmr_o    <= '0;
      trg_en_o <= 1'b0;
    end else if (load_i) begin
      vmin_o   <= sh_vmin;
      vmax_o   <= sh_vmax;
      stop_o   <= nxt_stop_o;
      tmr_o    <= nxt_tmr_o;
      trg_en_o <= sh_trg;
    end
  end
endmodule

// File: rtl/vcnt_trig.sv
module vcnt_trig #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trig_i,
  input  logic             trg_en_i,
  input  logic             halt_i,
  input  logic [CNT_W-1:0] main_i,
  input  logic [CNT_W-1:0] vmin_i,
  input  logic             clr_i,
  output logic             pend_o
);
  logic pend_q, accept;

  assign accept = trig_i && trg_en_i && (halt_i || (main_i >= vmin_i));
  assign pend_o = pend_q || accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_q <= 1'b0;
    else if (clr_i) pend_q <= 1'b0;
    else            pend_q <= pend_o;
  end
endmodule

// File: rtl/vcnt_core.sv
module vcnt_core #(
  parameter int CNT_W = 15,
  parameter int TMR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             pend_i,
  input  logic [CNT_W-1:0] vmax_i,
  input  logic [CNT_W-1:0] stop_i,
  input  logic [TMR_W-1:0] tmr_i,
  input  logic [CNT_W-1:0] nxt_stop_i,
  input  logic [TMR_W-1:0] nxt_tmr_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] main_o,
  output logic [TMR_W-1:0] sec_o,
  output logic             halt_o,
  output logic             fs_o
);
  logic [CNT_W-1:0] main_inc;
  logic [TMR_W-1:0] tmr_last;

  assign main_inc = main_o + CNT_W'(1);
  assign tmr_last = tmr_i - TMR_W'(1);
  assign wrap_o   = adv_i && (pend_i || (!halt_o && (main_o >= vmax_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_o <= '0;
      sec_o  <= '0;
      halt_o <= 1'b0;
      fs_o   <= 1'b0;
    end else begin
      fs_o <= 1'b0;
      if (wrap_o) begin
        main_o <= '0;
        sec_o  <= '0;
        halt_o <= (nxt_stop_i == '0) && (nxt_tmr_i != '0);
        fs_o   <= 1'b1;
      end else if (adv_i) begin
        if (halt_o) begin
          if (sec_o == tmr_last) begin
            halt_o <= 1'b0;
            sec_o  <= '0;
          end else begin
            sec_o <= sec_o + TMR_W'(1);
          end
        end else begin
          main_o <= main_inc;
          if ((main_inc == stop_i) && (tmr_i != '0)) begin
            halt_o <= 1'b1;
            sec_o  <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/vcnt_halt_ext.sv
module vcnt_halt_ext
  import vcnt_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int TMR_W  = 16,
  parameter int DATA_W = (CNT_W > TMR_W) ? CNT_W : TMR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              trig_i,
  input  logic              wr_en_i,
  input  logic [CFG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  main_cnt_o,
  output logic [TMR_W-1:0]  sec_cnt_o,
  output logic              frame_start_o,
  output logic              halt_o,
  output logic              vblank_o
);
  logic [CNT_W-1:0] vmin, vmax, stop, nxt_stop;
  logic [TMR_W-1:0] tmr, nxt_tmr;
  logic             trg_en, pend, wrap;

  vcnt_cfg #(.CNT_W(CNT_W), .TMR_W(TMR_W), .DATA_W(DATA_W)) u_cfg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(wrap), .vmin_o(vmin), .vmax_o(vmax), .stop_o(stop),
    .tmr_o(tmr), .trg_en_o(trg_en), .nxt_stop_o(nxt_stop), .nxt_tmr_o(nxt_tmr)
  );

  vcnt_trig #(.CNT_W(CNT_W)) u_trig (
    .clk_i, .rst_ni, .trig_i, .trg_en_i(trg_en), .halt_i(halt_o),
    .main_i(main_cnt_o), .vmin_i(vmin), .clr_i(wrap), .pend_o(pend)
  );

  vcnt_core #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_core (
    .clk_i, .rst_ni, .adv_i, .pend_i(pend), .vmax_i(vmax), .stop_i(stop),
    .tmr_i(tmr), .nxt_stop_i(nxt_stop), .nxt_tmr_i(nxt_tmr),
    .wrap_o(wrap), .main_o(main_cnt_o), .sec_o(sec_cnt_o),
    .halt_o(halt_o), .fs_o(frame_start_o)
  );

  assign vblank_o = main_cnt_o >= stop;
endmodule

// File: rtl/vcnt_halt_ext_chk.sv
module vcnt_halt_ext_chk #(
  parameter int CNT_W = 15,
  parameter int TMR_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             adv_i,
  input logic [CNT_W-1:0] main_cnt_o,
  input logic [TMR_W-1:0] sec_cnt_o,
  input logic             frame_start_o,
  input logic             halt_o,
  input logic             vblank_o
);
  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> ($stable(main_cnt_o) && $stable(sec_cnt_o) && !frame_start_o)); // R3

  AST_MAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !halt_o) |=> (frame_start_o || (main_cnt_o == $past(main_cnt_o) + CNT_W'(1)))); // R2

  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> (frame_start_o || $stable(main_cnt_o))); // R4

  AST_SEC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_o |-> (sec_cnt_o == '0)); // R5

  AST_FS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> ((main_cnt_o == '0) && (sec_cnt_o == '0))); // R8

  AST_FS_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> $past(adv_i)); // R8

  AST_HALT_VBLANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> vblank_o); // R11
endmodule

bind vcnt_halt_ext vcnt_halt_ext_chk #(.CNT_W(CNT_W), .TMR_W(TMR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(adv_i), .main_cnt_o(main_cnt_o),
  .sec_cnt_o(sec_cnt_o), .frame_start_o(frame_start_o), .halt_o(halt_o),
  .vblank_o(vblank_o)
);

// File: tb/vcnt_halt_ext_test.sv
`timescale 1ns/1ps
module vcnt_halt_ext_test;
  localparam int CW = 6;
  localparam int TW = 5;
  localparam int DW = 6;
  localparam int NV = 24;

  typedef struct packed {
    logic          adv;
    logic          trig;
    logic [CW-1:0] m;
    logic [TW-1:0] s;
    logic          h;
    logic          f;
    logic          v;
  } vec_t;

  // config in force: vmin 2, vmax 6, stop 4, timer 5, trigger on
  localparam vec_t TBL [NV] = '{
    // R5 worked frame: 12 lines, R3 idle row at index 2
    '{1'b1,1'b0,6'd1,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd2,5'd0,1'b0,1'b0,1'b0},
    '{1'b0,1'b0,6'd2,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd3,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd4,5'd0,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd4,5'd1,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd4,5'd2,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd4,5'd3,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd4,5'd4,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd4,5'd0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,6'd5,5'd0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,6'd6,5'd0,1'b0,1'b0,1'b1},
    '{1'b1,1'b0,6'd0,5'd0,1'b0,1'b1,1'b0},
    // R7 trigger inside the freeze, without advance, then wrap
    '{1'b1,1'b0,6'd1,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd2,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd3,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd4,5'd0,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd4,5'd1,1'b1,1'b0,1'b1},
    '{1'b0,1'b1,6'd4,5'd1,1'b1,1'b0,1'b1},
    '{1'b1,1'b0,6'd0,5'd0,1'b0,1'b1,1'b0},
    // R7 trigger below minimum rejected, trigger at minimum with advance
    '{1'b0,1'b1,6'd0,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd1,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b0,6'd2,5'd0,1'b0,1'b0,1'b0},
    '{1'b1,1'b1,6'd0,5'd0,1'b0,1'b1,1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          adv_i = 1'b0;
  logic          trig_i = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    wr_addr_i = '0;
  logic [DW-1:0] wr_data_i = '0;
  logic [CW-1:0] main_cnt_o;
  logic [TW-1:0] sec_cnt_o;
  logic          frame_start_o, halt_o, vblank_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vcnt_halt_ext #(.CNT_W(CW), .TMR_W(TW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .adv_i(adv_i), .trig_i(trig_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .main_cnt_o(main_cnt_o), .sec_cnt_o(sec_cnt_o),
    .frame_start_o(frame_start_o), .halt_o(halt_o), .vblank_o(vblank_o)
  );

  function automatic logic [CW+TW+2:0] pk(input logic [CW-1:0] m, input logic [TW-1:0] s,
                                          input logic h, input logic f, input logic v);
    return {m, s, h, f, v};
  endfunction

  task automatic chk(input string req, input logic [CW+TW+2:0] exp);
    logic [CW+TW+2:0] act;
    act = {main_cnt_o, sec_cnt_o, halt_o, frame_start_o, vblank_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s main/sec/halt/fs/vb act=%0d/%0d/%0b/%0b/%0b exp=%0d/%0d/%0b/%0b/%0b",
               req, act[CW+TW+2:TW+3], act[TW+2:3], act[2], act[1], act[0],
               exp[CW+TW+2:TW+3], exp[TW+2:3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic tick(input logic a, input logic t);
    adv_i = a;
    trig_i = t;
    @(posedge clk);
    #1;
    adv_i = 1'b0;
    trig_i = 1'b0;
  endtask

  task automatic adv_n(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 1'b0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    wr_en_i = 1'b1;
    wr_addr_i = a;
    wr_data_i = d;
    @(posedge clk);
    #1;
    wr_en_i = 1'b0;
  endtask

  function automatic string row_req(input int i);
    if (i == 2) return "R3";
    if (i < 13) return "R5";
    return "R7";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(posedge clk); #1;
    chk("R1", pk(6'd0, 5'd0, 1'b0, 1'b0, 1'b0));

    // R9: shadow writes, live settings untouched until the wrap
    wr(3'd0, 6'd2);
    wr(3'd1, 6'd6);
    wr(3'd2, 6'd4);
    wr(3'd3, 6'd5);
    wr(3'd4, 6'd1);
    wr(3'd5, 6'd9);   // unused address, ignored
    adv_n(10);
    chk("R9", pk(6'd10, 5'd0, 1'b0, 1'b0, 1'b0));
    adv_n(53);
    chk("R11", pk(6'd63, 5'd0, 1'b0, 1'b0, 1'b1));
    tick(1'b1, 1'b0);
    chk("R2", pk(6'd0, 5'd0, 1'b0, 1'b1, 1'b0));

    for (int i = 0; i < NV; i++) begin
      tick(TBL[i].adv, TBL[i].trig);
      chk(row_req(i), pk(TBL[i].m, TBL[i].s, TBL[i].h, TBL[i].f, TBL[i].v));
    end

    // R6: timer 0 means no freeze
    wr(3'd3, 6'd0);
    adv_n(2);
    tick(1'b1, 1'b1);
    chk("R8", pk(6'd0, 5'd0, 1'b0, 1'b1, 1'b0));
    adv_n(4);
    chk("R6", pk(6'd4, 5'd0, 1'b0, 1'b0, 1'b1));
    adv_n(2);
    chk("R6", pk(6'd6, 5'd0, 1'b0, 1'b0, 1'b1));
    tick(1'b1, 1'b0);
    chk("R6", pk(6'd0, 5'd0, 1'b0, 1'b1, 1'b0));

    // R7: trigger disabled is ignored
    wr(3'd4, 6'd0);
    adv_n(7);
    chk("R2", pk(6'd0, 5'd0, 1'b0, 1'b1, 1'b0));
    adv_n(3);
    tick(1'b0, 1'b1);
    tick(1'b1, 1'b0);
    chk("R7", pk(6'd4, 5'd0, 1'b0, 1'b0, 1'b1));

    // R10: min above stop with trigger and timer -> freeze refused
    wr(3'd0, 6'd5);
    wr(3'd2, 6'd2);
    wr(3'd3, 6'd3);
    wr(3'd4, 6'd1);
    adv_n(2);
    tick(1'b1, 1'b0);
    chk("R9", pk(6'd0, 5'd0, 1'b0, 1'b1, 1'b0));
    adv_n(2);
    chk("R10", pk(6'd2, 5'd0, 1'b0, 1'b0, 1'b0));

    // R12: stop line 0 freezes from frame start
    wr(3'd0, 6'd0);
    wr(3'd2, 6'd0);
    wr(3'd3, 6'd2);
    adv_n(4);
    chk("R10", pk(6'd6, 5'd0, 1'b0, 1'b0, 1'b0));
    tick(1'b1, 1'b0);
    chk("R12", pk(6'd0, 5'd0, 1'b1, 1'b1, 1'b1));
    tick(1'b1, 1'b0);
    chk("R12", pk(6'd0, 5'd1, 1'b1, 1'b0, 1'b1));
    tick(1'b1, 1'b0);
    chk("R5", pk(6'd0, 5'd0, 1'b0, 1'b0, 1'b1));
    tick(1'b1, 1'b0);
    chk("R2", pk(6'd1, 5'd0, 1'b0, 1'b0, 1'b1));

    // R1: reset mid-frame
    rst_ni = 1'b0;
    #5;
    chk("R1", pk(6'd0, 5'd0, 1'b0, 1'b0, 1'b0));
    @(posedge clk); #1 rst_ni = 1'b1;
    adv_n(4);
    chk("R1", pk(6'd4, 5'd0, 1'b0, 1'b0, 1'b0));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule